// File: doc/BRIEF.md
# Loop Offset Calibration Sequencer

This block trims the offset control of a tracking loop without software help. After a start strobe it writes the mid-scale trim code, lets the loop settle, samples an 8-bit loop-stress reading and nudges the trim by one code toward the side that brings the reading back to mid-scale. It repeats until the reading lands inside a fixed acceptance window, or until the trim sits on a rail with the reading still outside. A rail failure puts the trim back to mid-scale.

Settling is either timed or polled, chosen by a mode pin. In timed mode a down-counter loaded from a settle-count input sets the wait after every trim write. In polled mode the sequencer waits for a conversion-complete flag, and only counts a flag that went low and then high again after the write, so an old high level is not mistaken for a new result. A step guard ends a search that never converges. There is no data stream here: every pin is a plain control, status or level signal, and nothing applies back-pressure.

Top module: `trim_cal_seq`

## Requirements
- R1: A start pulse seen while idle sets the trim to 128 and makes busy high on the next cycle.
- R2: In timed mode (poll_mode=0), with settle count S, each reading is taken exactly S+1 cycles after the trim write that precedes it.
- R3: In polled mode (poll_mode=1), a reading is taken only when conv_done is high after conv_done was sampled low at some point since the last trim write; a flag held high across the write does not end the wait.
- R4: A reading from 116 to 140 inclusive ends the run with a one-cycle done pulse, pass=1, and the trim left at the value that gave that reading.
- R5: A reading above 140 lowers the trim by one; a reading below 116 raises it by one; the trim never moves by any other amount while busy.
- R6: A reading outside the window while the trim is 0 or 255 ends the run with done, pass=0 and the trim rewritten to 128.
- R7: When MAX_STEPS trim steps (default 256) have been made and the next reading is still outside the window, the run ends with done, pass=0 and trim 128.
- R8: done is high for exactly one cycle per run; trim and pass then hold their values until the next start.
- R9: A start pulse while busy has no effect on the trim, the step sequence or the run's timing.
- R10: A synchronous reset puts the block in idle with trim=128, busy=0, done=0 and pass=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a calibration run (honoured only when idle) |
| poll_mode | input | 1 | 0: timed settling; 1: wait for conv_done |
| settle_cnt | input | SETTLE_W | Extra settle cycles after each trim write in timed mode |
| conv_done | input | 1 | Conversion-complete flag from the stress measurement |
| meas | input | 8 | Loop-stress reading |
| trim | output | 8 | Offset trim code driven to the loop |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run: 1 window hit, 0 failure |

## Verification
The embedded properties take for granted that reset is held for at least two clocks, that poll_mode and settle_cnt stay fixed for the length of a run, and that meas is steady in the cycle a decision is made and the one after. The bench keeps to this by changing mode, settle count and loop model only at idle, and by modelling the loop as a combinational function of trim, so the reading follows each trim write at once and holds until the next one. The conversion flag is moved only at falling clock edges.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [1:0] {
    VERDICT_INSIDE = 2'd0,
    VERDICT_HIGH   = 2'd1,
    VERDICT_LOW    = 2'd2
  } verdict_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SETTLE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/trim_window_cmp.sv
module trim_window_cmp
  import trim_cal_pkg::*;
#(
  parameter int W   = 8,
  parameter int MID = 128,
  parameter int TOL = 12
) (
  input  logic [W-1:0] meas,
  output verdict_e     verdict
);
  localparam logic [W-1:0] LO_EDGE = W'(MID - TOL);
  localparam logic [W-1:0] HI_EDGE = W'(MID + TOL);

  always_comb begin
    if (meas > HI_EDGE)      verdict = VERDICT_HIGH;
    else if (meas < LO_EDGE) verdict = VERDICT_LOW;
    else                     verdict = VERDICT_INSIDE;
  end
endmodule

// File: rtl/trim_settle_wait.sv
module trim_settle_wait #(
  parameter int SETTLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic                active,
  input  logic                poll_mode,
  input  logic [SETTLE_W-1:0] settle_cnt,
  input  logic                conv_done,
  output logic                ready
);
  logic [SETTLE_W-1:0] cnt_q;
  logic                low_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      low_seen_q <= 1'b0;
    end else if (arm) begin
      cnt_q      <= settle_cnt;
      low_seen_q <= 1'b0;
    end else if (active) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (!conv_done)  low_seen_q <= 1'b1;
    end
  end

  assign ready = active && (poll_mode ? (low_seen_q && conv_done) : (cnt_q == '0));

  // R3: a poll-mode completion needs a low flag sampled after the last arm
  a_r3_fresh_flag: assert property (@(posedge clk) disable iff (rst)
    (arm) |=> !(poll_mode && ready));
endmodule

// File: rtl/trim_step_guard.sv
module trim_step_guard #(
  parameter int MAX_STEPS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic limit_hit
);
  localparam int CW = $clog2(MAX_STEPS + 1);
  logic [CW-1:0] steps_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                       steps_q <= '0;
    else if (inc && !limit_hit)           steps_q <= steps_q + 1'b1;
  end

  assign limit_hit = (steps_q == CW'(MAX_STEPS));
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
  import trim_cal_pkg::*;
#(
  parameter int SETTLE_W  = 24,
  parameter int MAX_STEPS = 256,
  parameter int MID       = 128,
  parameter int TOL       = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                poll_mode,
  input  logic [SETTLE_W-1:0] settle_cnt,
  input  logic                conv_done,
  input  logic [7:0]          meas,
  output logic [7:0]          trim,
  output logic                busy,
  output logic                done,
  output logic                pass
);
  localparam logic [7:0] TRIM_MID = 8'(MID);
  localparam logic [7:0] WIN_LO   = 8'(MID - TOL);
  localparam logic [7:0] WIN_HI   = 8'(MID + TOL);

  seq_state_e state_q;
  logic [7:0] trim_q;
  logic       done_q, pass_q;
  verdict_e   verdict;
  logic       ready, limit_hit;
  logic       go, decide, in_win, at_rail, give_up, step;

  trim_window_cmp #(.W(8), .MID(MID), .TOL(TOL)) u_cmp (
    .meas    (meas),
    .verdict (verdict)
  );

  trim_settle_wait #(.SETTLE_W(SETTLE_W)) u_wait (
    .clk        (clk),
    .rst        (rst),
    .arm        (go || step),
    .active     (state_q == SEQ_SETTLE),
    .poll_mode  (poll_mode),
    .settle_cnt (settle_cnt),
    .conv_done  (conv_done),
    .ready      (ready)
  );

  trim_step_guard #(.MAX_STEPS(MAX_STEPS)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .clr       (go),
    .inc       (step),
    .limit_hit (limit_hit)
  );

  assign go      = (state_q == SEQ_IDLE) && start;
  assign decide  = (state_q == SEQ_SETTLE) && ready;
  assign in_win  = (verdict == VERDICT_INSIDE);
  assign at_rail = (trim_q == 8'h00) || (trim_q == 8'hFF);
  assign give_up = !in_win && (at_rail || limit_hit);
  assign step    = decide && !in_win && !give_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      trim_q  <= TRIM_MID;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        trim_q  <= TRIM_MID;
        pass_q  <= 1'b0;
        state_q <= SEQ_SETTLE;
      end else if (decide) begin
        if (in_win) begin
          done_q  <= 1'b1;
          pass_q  <= 1'b1;
          state_q <= SEQ_IDLE;
        end else if (give_up) begin
          trim_q  <= TRIM_MID;
          done_q  <= 1'b1;
          pass_q  <= 1'b0;
          state_q <= SEQ_IDLE;
        end else if (verdict == VERDICT_HIGH) begin
          trim_q <= trim_q - 1'b1;
        end else begin
          trim_q <= trim_q + 1'b1;
        end
      end
    end
  end

  assign trim = trim_q;
  assign busy = (state_q == SEQ_SETTLE);
  assign done = done_q;
  assign pass = pass_q;

  a_r1_start_loads_mid: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && trim == TRIM_MID));

  a_r4_pass_in_window: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> ($past(meas) >= WIN_LO && $past(meas) <= WIN_HI));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && trim != $past(trim)) |->
      (trim == $past(trim) + 8'd1 || trim == $past(trim) - 8'd1));

  a_r6_fail_restores_mid: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (trim == TRIM_MID));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(trim) && $stable(pass)));
endmodule

// File: tb/sim_trim_cal_seq.sv
module sim_trim_cal_seq;
  localparam int SW = 24;
  localparam int MAXS = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          poll_mode = 1'b0;
  logic [SW-1:0] settle_cnt = '0;
  logic          conv_done = 1'b0;
  logic [7:0]    meas;
  logic [7:0]    trim;
  logic          busy, done, pass;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  offset = 0;
  bit  osc = 1'b0;

  typedef struct {
    int         edge_no;
    logic       pass;
    logic [7:0] trim;
    string      tag;
  } exp_t;
  exp_t expq[$];

  trim_cal_seq #(.SETTLE_W(SW), .MAX_STEPS(MAXS)) u0 (
    .clk(clk), .rst(rst), .start(start), .poll_mode(poll_mode),
    .settle_cnt(settle_cnt), .conv_done(conv_done), .meas(meas),
    .trim(trim), .busy(busy), .done(done), .pass(pass)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // loop model: reading rises with trim, clamped to 8 bits
  always_comb begin
    int v;
    if (osc) meas = trim[0] ? 8'd200 : 8'd50;
    else begin
      v = int'(trim) + offset;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      meas = 8'(v);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_meas(int t, int off, bit o);
    int v;
    if (o) return (t % 2 == 1) ? 200 : 50;
    v = t + off;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(cyc == e.edge_no, {e.tag, " R2 timing"}, cyc, e.edge_no);
        chk(pass == e.pass, {e.tag, " pass"}, int'(pass), int'(e.pass));
        chk(trim == e.trim, {e.tag, " final trim"}, int'(trim), int'(e.trim));
      end
    end
  end

  task automatic run_timed(int off, bit o, int s, bit extra_start, string tag);
    int t = 128;
    int n = 0;
    bit p = 1'b0;
    exp_t e;
    forever begin
      int m = model_meas(t, off, o);
      if (m >= 116 && m <= 140) begin p = 1'b1; break; end
      if (t == 0 || t == 255 || n == MAXS) begin p = 1'b0; t = 128; break; end
      t = (m > 140) ? t - 1 : t + 1;
      n++;
    end
    @(negedge clk);
    offset = off; osc = o; settle_cnt = SW'(s); poll_mode = 1'b0;
    start = 1'b1;
    e.edge_no = cyc + 1 + (n + 1) * (s + 1);
    e.pass = p; e.trim = 8'(t); e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    if (extra_start) begin
      repeat (5) @(negedge clk);
      start = 1'b1;               // R9: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (expq.size() != 0) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(trim == 8'(t), "R8 trim held", int'(trim), t);
    chk(pass == p, "R8 pass held", int'(pass), int'(p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(trim == 8'd128, "R10 reset trim", int'(trim), 128);
    chk(busy == 1'b0 && done == 1'b0 && pass == 1'b0, "R10 reset flags",
        int'({busy, done, pass}), 0);
    rst = 1'b0;
    @(negedge clk);

    run_timed(0,    1'b0, 2, 1'b0, "R4 centre");
    run_timed(-12,  1'b0, 0, 1'b0, "R4 low edge 116");
    run_timed(12,   1'b0, 1, 1'b0, "R4 high edge 140");
    run_timed(13,   1'b0, 3, 1'b0, "R5 one step down");
    run_timed(-13,  1'b0, 3, 1'b0, "R5 one step up");
    run_timed(40,   1'b0, 3, 1'b1, "R9 start ignored R5");
    run_timed(200,  1'b0, 1, 1'b0, "R6 bottom rail");
    run_timed(-200, 1'b0, 0, 1'b0, "R6 top rail");
    run_timed(0,    1'b1, 0, 1'b0, "R7 step guard");

    // R3: polled mode, a stale high flag must not end the wait
    begin
      exp_t e;
      offset = 0; osc = 1'b0; poll_mode = 1'b1; conv_done = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy == 1'b1 && done == 1'b0, "R3 stale flag ignored",
          int'({busy, done}), 2);
      conv_done = 1'b0;
      e.edge_no = cyc + 2; e.pass = 1'b1; e.trim = 8'd128; e.tag = "R3 fresh flag";
      expq.push_back(e);
      @(negedge clk);
      conv_done = 1'b1;
      while (expq.size() != 0) @(posedge clk);
      @(negedge clk);
      conv_done = 1'b0; poll_mode = 1'b0;
    end

    // R10: reset in the middle of a run
    offset = 200; settle_cnt = SW'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(trim != 8'd128, "R5 trim moved before reset", int'(trim), 127);
    rst = 1'b1;
    @(negedge clk);
    chk(trim == 8'd128 && busy == 1'b0 && done == 1'b0 && pass == 1'b0,
        "R10 mid-run reset", int'({trim, busy, done, pass}), 128 << 3);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && trim == 8'd128, "R10 stays idle", int'({trim, busy}), 256);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule